// File: doc/BRIEF.md
# Interrupt Source Routing Register Bank

This block gathers 32 level-sensitive interrupt requests and routes each one to one of two processor lines. A request counts as pending when its hardware input is high or when software has raised the matching bit in a software-request register. A per-source select register sends each source either to the normal line or to the fast line. The normal line also honours a per-source enable mask. The fast line does not use the enable mask.

Software reaches the bank through a word-addressed register bus with separate read and write strobes. The enable and software-request registers each have one address that sets bits and a second address that clears bits, so different drivers can change single bits without a read-modify-write. The bank also has read-only status views, a one-bit protection register and a fixed block of identification bytes. An access to an address that is not mapped is reported on an error output. The masked normal-line status vector is exported on its own port, for use by a separate vector priority unit.

Top module: `irq_route_bank`

## Requirements
- R1: Word offset 2 reads the raw pending vector, which is `reqIn` OR the software-request register.
- R2: Word offset 0 reads raw AND enable AND NOT select, and `irqStatusVec` carries the same vector. Word offset 1 reads raw AND select, whatever the enable register holds.
- R3: Writing word offset 4 sets every enable bit that has a 1 in the write data. Writing word offset 5 clears every enable bit that has a 1 in the write data. Reading word offset 4 returns the enable register.
- R4: Writing word offset 6 sets software-request bits and writing word offset 7 clears them, in both cases where the write data holds a 1. Reading word offset 6 returns the software-request register. Word offset 3 is the select register, written and read as a plain value.
- R5: A write to word offset 8 stores only bit 0 of the data. A read of word offset 8 returns that bit with all upper bits zero.
- R6: After reset the enable, select, software-request and protection registers are zero, and `irqOut`, `fiqOut` and `busErr` are low.
- R7: `irqOut` and `fiqOut` are registered. Each one is high on the clock after any bit of its status vector is set. After a register write, each follows the new state one clock after the write edge.
- R8: A write to word offset 0 changes no state and does not raise `busErr`.
- R9: Word offsets 0x3F8 to 0x3FF (byte offsets 0xFE0 to 0xFFC) read, in address order, the bytes 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, each zero-extended to 32 bits.
- R10: An unmapped access reads as zero and changes no state. `busErr` is high for the one cycle after the access edge. The unmapped reads are offsets 5, 7 and 9 to 0x3F7. The unmapped writes are offsets 1, 2 and 9 to 0x3FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 10 | Word address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational while `busRdEn` is high |
| busErr | output | 1 | One-cycle flag for an unmapped access |
| reqIn | input | 32 | Hardware request lines |
| irqOut | output | 1 | Normal interrupt line, registered |
| fiqOut | output | 1 | Fast interrupt line, registered |
| irqStatusVec | output | 32 | Enabled normal-line status for the vector unit |

## Verification
A software-request clear and a held-high hardware request can both act on the same source in the same cycle. The bench raises the line on `reqIn` and sets that source's software bit. It then writes the clear address while the line is still high. It checks that the software register reads zero while the raw view and `fiqOut` stay set. Once the hardware line drops, the raw view and the output must fall one clock later. A second overlap comes from a select write landing while `irqOut` is already high. On the next clock the source must move from the normal line to the fast line, with neither line carrying it at the same time.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int BUS_W = 32;

  // Word offsets of the register map
  localparam int OFS_IRQ_STAT = 0;
  localparam int OFS_FIQ_STAT = 1;
  localparam int OFS_RAW      = 2;
  localparam int OFS_SEL      = 3;
  localparam int OFS_EN_SET   = 4;
  localparam int OFS_EN_CLR   = 5;
  localparam int OFS_SW_SET   = 6;
  localparam int OFS_SW_CLR   = 7;
  localparam int OFS_PROT     = 8;

  typedef enum logic [3:0] {
    RD_NONE, RD_IRQ, RD_FIQ, RD_RAW, RD_SEL, RD_EN, RD_SOFT, RD_PROT, RD_ID
  } rdSel_e;

  typedef struct packed {
    logic       selWr;
    logic       enSet;
    logic       enClr;
    logic       softSet;
    logic       softClr;
    logic       protWr;
    rdSel_e     rdSel;
    logic [2:0] idIdx;
  } ctlBus_t;

  function automatic logic [7:0] idByte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = 8'h90;
      3'd1: b = 8'h11;
      3'd2: b = 8'h04;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output ctlBus_t           ctl,
  output logic              busErr
);
  logic idHit;
  logic rdMapped;
  logic wrMapped;

  // identification block occupies the top eight words
  assign idHit = (busAddr[ADDR_W-1:3] == '1);

  always_comb begin
    ctl       = '0;
    ctl.idIdx = busAddr[2:0];
    rdMapped  = 1'b0;
    wrMapped  = 1'b0;
    if (busRdEn) begin
      rdMapped = 1'b1;
      case (busAddr)
        ADDR_W'(OFS_IRQ_STAT): ctl.rdSel = RD_IRQ;
        ADDR_W'(OFS_FIQ_STAT): ctl.rdSel = RD_FIQ;
        ADDR_W'(OFS_RAW):      ctl.rdSel = RD_RAW;
        ADDR_W'(OFS_SEL):      ctl.rdSel = RD_SEL;
        ADDR_W'(OFS_EN_SET):   ctl.rdSel = RD_EN;
        ADDR_W'(OFS_SW_SET):   ctl.rdSel = RD_SOFT;
        ADDR_W'(OFS_PROT):     ctl.rdSel = RD_PROT;
        default: begin
          if (idHit) ctl.rdSel = RD_ID;
          else       rdMapped  = 1'b0;
        end
      endcase
    end
    if (busWrEn) begin
      wrMapped = 1'b1;
      case (busAddr)
        ADDR_W'(OFS_IRQ_STAT): ;  // read-only status, write dropped quietly
        ADDR_W'(OFS_SEL):      ctl.selWr   = 1'b1;
        ADDR_W'(OFS_EN_SET):   ctl.enSet   = 1'b1;
        ADDR_W'(OFS_EN_CLR):   ctl.enClr   = 1'b1;
        ADDR_W'(OFS_SW_SET):   ctl.softSet = 1'b1;
        ADDR_W'(OFS_SW_CLR):   ctl.softClr = 1'b1;
        ADDR_W'(OFS_PROT):     ctl.protWr  = 1'b1;
        default:               wrMapped    = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busErr <= 1'b0;
    else        busErr <= (busRdEn && !rdMapped) || (busWrEn && !wrMapped);
  end

  // R3: at most one write strobe per cycle
  p_one_wr_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.selWr, ctl.enSet, ctl.enClr, ctl.softSet, ctl.softClr, ctl.protWr}));

  // R8: quiet write to offset 0 never flags
  p_wr0_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && !busRdEn && busAddr == '0) |=> !busErr);

  // R10: error only follows a bus access
  p_err_after_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busErr |-> $past(busRdEn || busWrEn));
endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctlBus_t            ctl,
  input  logic [BUS_W-1:0]   wrData,
  input  logic [NUM_SRC-1:0] reqIn,
  output logic [BUS_W-1:0]   rdData,
  output logic [NUM_SRC-1:0] irqVec,
  output logic [NUM_SRC-1:0] fiqVec,
  output logic               irqOut,
  output logic               fiqOut
);
  logic [NUM_SRC-1:0] selReg, enReg, softReg, rawVec, wBits;
  logic               protReg;

  assign wBits  = wrData[NUM_SRC-1:0];
  assign rawVec = reqIn | softReg;
  assign irqVec = rawVec & enReg & ~selReg;
  assign fiqVec = rawVec & selReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selReg  <= '0;
      enReg   <= '0;
      softReg <= '0;
      protReg <= 1'b0;
      irqOut  <= 1'b0;
      fiqOut  <= 1'b0;
    end else begin
      if (ctl.selWr)        selReg  <= wBits;
      if (ctl.enSet)        enReg   <= enReg | wBits;
      else if (ctl.enClr)   enReg   <= enReg & ~wBits;
      if (ctl.softSet)      softReg <= softReg | wBits;
      else if (ctl.softClr) softReg <= softReg & ~wBits;
      if (ctl.protWr)       protReg <= wrData[0];
      irqOut <= |irqVec;
      fiqOut <= |fiqVec;
    end
  end

  always_comb begin
    case (ctl.rdSel)
      RD_IRQ:  rdData = BUS_W'(irqVec);
      RD_FIQ:  rdData = BUS_W'(fiqVec);
      RD_RAW:  rdData = BUS_W'(rawVec);
      RD_SEL:  rdData = BUS_W'(selReg);
      RD_EN:   rdData = BUS_W'(enReg);
      RD_SOFT: rdData = BUS_W'(softReg);
      RD_PROT: rdData = BUS_W'(protReg);
      RD_ID:   rdData = BUS_W'(idByte(ctl.idIdx));
      default: rdData = '0;
    endcase
  end

  // R3: set address leaves every written one set
  p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.enSet |=> ((enReg & $past(wBits)) == $past(wBits)));

  // R4: clear address leaves every written one clear
  p_soft_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.softClr |=> ((softReg & $past(wBits)) == '0));

  // R4: select holds without its strobe
  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.selWr |=> $stable(selReg));

  // R5: protection keeps bit 0 of the write
  p_prot_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.protWr |=> (protReg == $past(wrData[0])));

  // R2: no source is routed to both lines
  p_route_disjoint_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irqVec & fiqVec) == '0);
endmodule

// File: rtl/irq_route_bank.sv
module irq_route_bank
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [BUS_W-1:0]   busWrData,
  output logic [BUS_W-1:0]   busRdData,
  output logic               busErr,
  input  logic [NUM_SRC-1:0] reqIn,
  output logic               irqOut,
  output logic               fiqOut,
  output logic [NUM_SRC-1:0] irqStatusVec
);
  ctlBus_t            ctl;
  logic [NUM_SRC-1:0] fiqVec;

  irq_route_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .ctl(ctl), .busErr(busErr)
  );

  irq_route_dp #(.NUM_SRC(NUM_SRC)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wrData(busWrData), .reqIn(reqIn),
    .rdData(busRdData), .irqVec(irqStatusVec), .fiqVec(fiqVec),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );
endmodule

// File: tb/irq_route_bank_tb.sv
module irq_route_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        busErr;
  logic [31:0] reqIn = '0;
  logic        irqOut, fiqOut;
  logic [31:0] irqStatusVec;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_bank dut_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .busErr(busErr), .reqIn(reqIn), .irqOut(irqOut), .fiqOut(fiqOut),
    .irqStatusVec(irqStatusVec)
  );

  typedef struct packed {
    logic        isWr;
    logic [9:0]  addr;
    logic [31:0] req;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  tag;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t TBL [NVEC] = '{
    '{1'b0, 10'h004, 32'h0,  32'h0,        32'h0,   8'd6},  // R6 enable reset
    '{1'b0, 10'h003, 32'h0,  32'h0,        32'h0,   8'd6},  // R6 select reset
    '{1'b1, 10'h004, 32'h0,  32'hFF,       32'h0,   8'd3},  // R3 set
    '{1'b0, 10'h004, 32'h0,  32'h0,        32'hFF,  8'd3},
    '{1'b1, 10'h005, 32'h0,  32'h0F,       32'h0,   8'd3},  // R3 clear
    '{1'b0, 10'h004, 32'h0,  32'h0,        32'hF0,  8'd3},
    '{1'b1, 10'h006, 32'h0,  32'h300,      32'h0,   8'd4},  // R4 soft set
    '{1'b0, 10'h006, 32'h0,  32'h0,        32'h300, 8'd4},
    '{1'b0, 10'h002, 32'h11, 32'h0,        32'h311, 8'd1},  // R1 raw
    '{1'b1, 10'h003, 32'h11, 32'h100,      32'h0,   8'd4},  // R4 select
    '{1'b0, 10'h003, 32'h11, 32'h0,        32'h100, 8'd4},
    '{1'b0, 10'h000, 32'h11, 32'h0,        32'h10,  8'd2},  // R2 irq status
    '{1'b0, 10'h001, 32'h11, 32'h0,        32'h100, 8'd2},  // R2 fiq ignores enable
    '{1'b1, 10'h007, 32'h11, 32'h100,      32'h0,   8'd4},  // R4 soft clear
    '{1'b0, 10'h006, 32'h11, 32'h0,        32'h200, 8'd4},
    '{1'b0, 10'h001, 32'h11, 32'h0,        32'h0,   8'd2},
    '{1'b1, 10'h008, 32'h11, 32'hFFFFFFFF, 32'h0,   8'd5},  // R5
    '{1'b0, 10'h008, 32'h11, 32'h0,        32'h1,   8'd5},
    '{1'b0, 10'h3F8, 32'h11, 32'h0,        32'h90,  8'd9},  // R9
    '{1'b0, 10'h3FF, 32'h11, 32'h0,        32'hB1,  8'd9}
  };

  function automatic logic [31:0] idExp(input int i);
    logic [7:0] b [8] = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return {24'h0, b[i]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 v = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check("R6 irqOut", {31'h0, irqOut}, 32'h0);
    check("R6 fiqOut", {31'h0, fiqOut}, 32'h0);
    check("R6 busErr", {31'h0, busErr}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      reqIn = TBL[i].req;
      if (TBL[i].isWr) wr(TBL[i].addr, TBL[i].data);
      else begin
        rd(TBL[i].addr, v);
        check($sformatf("R%0d vec%0d", TBL[i].tag, i), v, TBL[i].exp);
      end
    end

    // R6: reset again clears every register
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; reqIn = '0;
    check("R6 irqOut after reset", {31'h0, irqOut}, 32'h0);
    check("R6 fiqOut after reset", {31'h0, fiqOut}, 32'h0);
    rd(10'h004, v); check("R6 enable", v, 32'h0);
    rd(10'h006, v); check("R6 soft", v, 32'h0);
    rd(10'h008, v); check("R6 prot", v, 32'h0);

    // R7: output lags a register write by one clock
    reqIn = 32'h8;
    wr(10'h004, 32'h8);
    check("R2 irqStatusVec", irqStatusVec, 32'h8);
    check("R7 irqOut not yet", {31'h0, irqOut}, 32'h0);
    @(negedge clk);
    check("R7 irqOut rises", {31'h0, irqOut}, 32'h1);
    wr(10'h003, 32'h8);
    check("R7 irqOut holds one clock", {31'h0, irqOut}, 32'h1);
    check("R7 fiqOut not yet", {31'h0, fiqOut}, 32'h0);
    @(negedge clk);
    check("R7 irqOut falls", {31'h0, irqOut}, 32'h0);
    check("R7 fiqOut rises", {31'h0, fiqOut}, 32'h1);

    // R8: write to the status word is dropped quietly
    wr(10'h000, 32'hFFFFFFFF);
    check("R8 no error", {31'h0, busErr}, 32'h0);
    rd(10'h004, v); check("R8 enable kept", v, 32'h8);
    rd(10'h003, v); check("R8 select kept", v, 32'h8);
    rd(10'h006, v); check("R8 soft kept", v, 32'h0);

    // R10: unmapped accesses
    rd(10'h020, v); check("R10 read zero", v, 32'h0);
    check("R10 err pulse", {31'h0, busErr}, 32'h1);
    @(negedge clk);
    check("R10 err one cycle", {31'h0, busErr}, 32'h0);
    wr(10'h001, 32'hFFFFFFFF);
    check("R10 err on ro write", {31'h0, busErr}, 32'h1);
    rd(10'h002, v); check("R10 raw unchanged", v, 32'h8);
    wr(10'h020, 32'hFFFFFFFF);
    check("R10 err on unmapped write", {31'h0, busErr}, 32'h1);
    rd(10'h004, v); check("R10 enable unchanged", v, 32'h8);
    rd(10'h003, v); check("R10 select unchanged", v, 32'h8);
    rd(10'h005, v); check("R10 clear word reads zero", v, 32'h0);
    check("R10 err on clear word read", {31'h0, busErr}, 32'h1);

    // R4 with R1: soft clear while hardware line still high
    wr(10'h006, 32'h8);
    wr(10'h007, 32'h8);
    rd(10'h006, v); check("R4 soft cleared", v, 32'h0);
    rd(10'h002, v); check("R1 raw held by line", v, 32'h8);
    check("R7 fiqOut stays", {31'h0, fiqOut}, 32'h1);
    reqIn = '0;
    rd(10'h002, v); check("R1 raw falls", v, 32'h0);
    check("R7 fiqOut falls", {31'h0, fiqOut}, 32'h0);

    // R9: full identification block
    for (int i = 0; i < 8; i++) begin
      rd(10'h3F8 + 10'(i), v);
      check($sformatf("R9 id%0d", i), v, idExp(i));
    end

    finishRun();
  end
endmodule